// File: doc/BRIEF.md
# DRAM Rank Low-Power State Controller

This block sits beside the command scheduler of one DRAM rank and decides when that rank drops into a low-power state and when it must come back out. It keeps a running count of command events that have been scheduled but have not yet completed. Read/write bursts, precharges and refreshes each add one to the count when scheduled and remove one when they complete. Activates are not counted, because every activate is followed by a burst that is counted. It also watches the rank's read and write queue occupancy, whether every bank is closed, and the current bus direction.

Three points can trigger entry into a low-power state: the return of read data, the completion of a precharge, and the end of a refresh. Which state is entered depends on the bank status and on the state the rank was in before the refresh. The scheduler receives one-cycle strobes that tell it to enter or leave power-down and to enter or leave self-refresh. After any exit, a busy flag is held high for a fixed settling window so that no new command issues during it.

All pins are plain control and status levels or one-cycle pulses. Data does not pass through the block, so there is no valid/ready handshake and no back-pressure. Every decision is registered: a strobe and the matching state change appear together, in the cycle after the inputs that caused them are sampled.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: The outstanding-event count rises by one for a cycle with `evt_sched` alone and falls by one for a cycle with `evt_done` alone. It is unchanged when both pulse in the same cycle, stays at zero when it would go below zero, and stays at its maximum when it would go above it.
- R2: From ACTIVE, entry into a power-down state is taken only if three conditions all hold. The count, after that cycle's update, is zero. Both queue counts are zero. `acc_req` is low.
- R3: In ACTIVE, if `rd_ret` pulses while `banks_closed` is 0 and R2 is met, the next cycle shows state ACT_PDN and a one-cycle `pd_enter`.
- R4: In ACTIVE, if `rd_ret` or `pre_done` pulses while `banks_closed` is 1 and R2 is met, the next cycle shows state PRE_PDN and a one-cycle `pd_enter`.
- R5: `ref_req` in ACT_PDN or PRE_PDN moves the block to REFRESH and gives a one-cycle `pd_exit`. `ref_req` in ACTIVE moves it to REFRESH without any strobe. On `ref_done`, a prior state of ACT_PDN leads to PRE_PDN with `pd_enter`, and a prior state of ACTIVE leads back to ACTIVE with no strobe.
- R6: On `ref_done` with a prior state of PRE_PDN, the block returns to PRE_PDN with `pd_enter` if either queue is nonzero. If both queues are empty, it goes to SREF with `sr_enter`.
- R7: `acc_req` in ACT_PDN or PRE_PDN moves the block to ACTIVE with a one-cycle `pd_exit`. When `ref_req` and `acc_req` arrive in the same cycle, `ref_req` takes priority.
- R8: In SREF, a nonzero read queue, or a nonzero write queue while `bus_wr` is 1, moves the block to ACTIVE with a one-cycle `sr_exit`. A nonzero write queue with `bus_wr` at 0 leaves the block in SREF.
- R9: `busy` is high for exactly `XIT_LAT` cycles, starting with the cycle that shows `pd_exit` or `sr_exit`.
- R10: `state` is encoded as ACTIVE=0, ACT_PDN=1, PRE_PDN=2, REFRESH=3, SREF=4. During reset and after it, `state` is 0 and all strobes and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_sched | input | 1 | Pulse: a burst, precharge or refresh event was scheduled |
| evt_done | input | 1 | Pulse: a counted event completed |
| banks_closed | input | 1 | Every bank of the rank is precharged |
| rdq_cnt | input | QCNT_W | Read-queue entries for this rank |
| wrq_cnt | input | QCNT_W | Write-queue entries for this rank |
| bus_wr | input | 1 | Bus is currently in write direction |
| rd_ret | input | 1 | Pulse: read data returned from the rank |
| pre_done | input | 1 | Pulse: a precharge completed |
| ref_req | input | 1 | Pulse: a refresh is about to be issued |
| ref_done | input | 1 | Pulse: the refresh completed |
| acc_req | input | 1 | A read or write access must issue to the rank |
| pd_enter | output | 1 | One-cycle power-down entry strobe |
| pd_exit | output | 1 | One-cycle power-down exit strobe |
| sr_enter | output | 1 | One-cycle self-refresh entry strobe |
| sr_exit | output | 1 | One-cycle self-refresh exit strobe |
| busy | output | 1 | Exit settling window; blocks command issue |
| state | output | 3 | Current power state, encoded per R10 |

## Verification
The in-line properties check several rules on every cycle. The count holds when both pulses coincide and stops at zero. An entry from ACTIVE happens only with a zero count and empty queues. Each exit strobe comes only from a matching low-power state. `busy` rises after an exit.

Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. These scenarios cover the choice between active and precharge power-down, the prior-state rules at the end of a refresh, the priority of refresh over access, the write-queue-with-read-bus case in self-refresh, and the exact length of the busy window.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;
  typedef enum logic [2:0] {
    PS_ACTIVE  = 3'd0,
    PS_ACT_PDN = 3'd1,
    PS_PRE_PDN = 3'd2,
    PS_REFRESH = 3'd3,
    PS_SREF    = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/rank_evt_cnt.sv
module rank_evt_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sched,
  input  logic             done,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  always_comb begin
    cnt_nxt = cnt_q;
    if (sched && !done && cnt_q != CMAX) cnt_nxt = cnt_q + 1'b1;
    else if (done && !sched && cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && done) |=> $stable(cnt_q)); // R1
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && done && !sched) |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/rank_xit_timer.sv
module rank_xit_timer #(
  parameter int XIT_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int XW = $clog2(XIT_LAT + 1);
  localparam logic [XW-1:0] LOADV = XW'(XIT_LAT);

  logic [XW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= LOADV;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R9
endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import rank_pwr_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int QCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic              banks_closed,
  input  logic [QCNT_W-1:0] rdq_cnt,
  input  logic [QCNT_W-1:0] wrq_cnt,
  input  logic              bus_wr,
  input  logic              rd_ret,
  input  logic              pre_done,
  input  logic              ref_req,
  input  logic              ref_done,
  input  logic              acc_req,
  output pwr_state_e        st_q,
  output logic              xit_start,
  output logic              pd_enter,
  output logic              pd_exit,
  output logic              sr_enter,
  output logic              sr_exit
);
  pwr_state_e st_n, pr_q, pr_n;
  logic pe, px, se, sx;
  logic q_any, idle;

  assign q_any = (rdq_cnt != '0) || (wrq_cnt != '0);
  assign idle  = (cnt_nxt == '0) && !q_any && !acc_req;

  always_comb begin
    st_n = st_q;
    pr_n = pr_q;
    pe = 1'b0; px = 1'b0; se = 1'b0; sx = 1'b0;
    case (st_q)
      PS_ACTIVE: begin
        if (ref_req) begin
          st_n = PS_REFRESH;
          pr_n = PS_ACTIVE;
        end else if (idle && rd_ret && !banks_closed) begin
          st_n = PS_ACT_PDN;
          pe = 1'b1;
        end else if (idle && (rd_ret || pre_done) && banks_closed) begin
          st_n = PS_PRE_PDN;
          pe = 1'b1;
        end
      end
      PS_ACT_PDN, PS_PRE_PDN: begin
        if (ref_req) begin
          st_n = PS_REFRESH;
          pr_n = st_q;
          px = 1'b1;
        end else if (acc_req) begin
          st_n = PS_ACTIVE;
          px = 1'b1;
        end
      end
      PS_REFRESH: begin
        if (ref_done) begin
          case (pr_q)
            PS_ACT_PDN: begin
              st_n = PS_PRE_PDN;
              pe = 1'b1;
            end
            PS_PRE_PDN: begin
              if (q_any) begin
                st_n = PS_PRE_PDN;
                pe = 1'b1;
              end else begin
                st_n = PS_SREF;
                se = 1'b1;
              end
            end
            default: st_n = PS_ACTIVE;
          endcase
        end
      end
      PS_SREF: begin
        if ((rdq_cnt != '0) || ((wrq_cnt != '0) && bus_wr)) begin
          st_n = PS_ACTIVE;
          sx = 1'b1;
        end
      end
      default: st_n = PS_ACTIVE;
    endcase
  end

  assign xit_start = px | sx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_ACTIVE;
      pr_q     <= PS_ACTIVE;
      pd_enter <= 1'b0;
      pd_exit  <= 1'b0;
      sr_enter <= 1'b0;
      sr_exit  <= 1'b0;
    end else begin
      st_q     <= st_n;
      pr_q     <= pr_n;
      pd_enter <= pe;
      pd_exit  <= px;
      sr_enter <= se;
      sr_exit  <= sx;
    end
  end

  AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_enter && $past(st_q) == PS_ACTIVE) |-> (cnt_q == '0 && $past(!q_any))); // R2
  AST_PDX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    pd_exit |-> ($past(st_q) == PS_ACT_PDN || $past(st_q) == PS_PRE_PDN)); // R7
  AST_SRX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |-> ($past(st_q) == PS_SREF && st_q == PS_ACTIVE)); // R8
  AST_SRE_DST: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |-> (st_q == PS_SREF && $past(st_q) == PS_REFRESH)); // R6
endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl
  import rank_pwr_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int QCNT_W  = 4,
  parameter int XIT_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_sched,
  input  logic              evt_done,
  input  logic              banks_closed,
  input  logic [QCNT_W-1:0] rdq_cnt,
  input  logic [QCNT_W-1:0] wrq_cnt,
  input  logic              bus_wr,
  input  logic              rd_ret,
  input  logic              pre_done,
  input  logic              ref_req,
  input  logic              ref_done,
  input  logic              acc_req,
  output logic              pd_enter,
  output logic              pd_exit,
  output logic              sr_enter,
  output logic              sr_exit,
  output logic              busy,
  output logic [2:0]        state
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             xit_start;
  pwr_state_e       st_q;

  rank_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sched(evt_sched), .done(evt_done),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  rank_pwr_fsm #(.CNT_W(CNT_W), .QCNT_W(QCNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .banks_closed(banks_closed), .rdq_cnt(rdq_cnt), .wrq_cnt(wrq_cnt),
    .bus_wr(bus_wr), .rd_ret(rd_ret), .pre_done(pre_done),
    .ref_req(ref_req), .ref_done(ref_done), .acc_req(acc_req),
    .st_q(st_q), .xit_start(xit_start), .pd_enter(pd_enter),
    .pd_exit(pd_exit), .sr_enter(sr_enter), .sr_exit(sr_exit)
  );

  rank_xit_timer #(.XIT_LAT(XIT_LAT)) u_xit (
    .clk(clk), .rst_n(rst_n), .start(xit_start), .busy(busy)
  );

  assign state = st_q;

  AST_BUSY_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_exit || sr_exit) |-> busy); // R9
endmodule

// File: tb/rank_pwr_ctrl_tb.sv
module rank_pwr_ctrl_tb;
  localparam int CNT_W = 4, QCNT_W = 4, XIT_LAT = 3;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_sched = 0, evt_done = 0, banks_closed = 0, bus_wr = 0;
  logic rd_ret = 0, pre_done = 0, ref_req = 0, ref_done = 0, acc_req = 0;
  logic [QCNT_W-1:0] rdq_cnt = '0, wrq_cnt = '0;
  logic pd_enter, pd_exit, sr_enter, sr_exit, busy;
  logic [2:0] state;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  rank_pwr_ctrl #(.CNT_W(CNT_W), .QCNT_W(QCNT_W), .XIT_LAT(XIT_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_sched(evt_sched), .evt_done(evt_done),
    .banks_closed(banks_closed), .rdq_cnt(rdq_cnt), .wrq_cnt(wrq_cnt),
    .bus_wr(bus_wr), .rd_ret(rd_ret), .pre_done(pre_done), .ref_req(ref_req),
    .ref_done(ref_done), .acc_req(acc_req), .pd_enter(pd_enter),
    .pd_exit(pd_exit), .sr_enter(sr_enter), .sr_exit(sr_exit),
    .busy(busy), .state(state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_st, m_pr, m_b, nc;
  bit m_pe, m_px, m_se, m_sx, idle, qany;
  bit lastq_empty;
  int last_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_pr = 0; m_b = 0;
      m_pe = 0; m_px = 0; m_se = 0; m_sx = 0;
      lastq_empty = 1; last_cnt = 0;
    end else begin
      nc = m_cnt;
      if (evt_sched && !evt_done) nc = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
      else if (evt_done && !evt_sched) nc = (m_cnt == 0) ? 0 : m_cnt - 1;
      qany = (rdq_cnt != 0) || (wrq_cnt != 0);
      idle = (nc == 0) && !qany && !acc_req;
      lastq_empty = !qany;
      m_pe = 0; m_px = 0; m_se = 0; m_sx = 0;
      case (m_st)
        0: if (ref_req) begin m_st = 3; m_pr = 0; end
           else if (idle && rd_ret && !banks_closed) begin m_st = 1; m_pe = 1; end
           else if (idle && (rd_ret || pre_done) && banks_closed) begin m_st = 2; m_pe = 1; end
        1, 2: if (ref_req) begin m_pr = m_st; m_st = 3; m_px = 1; end
              else if (acc_req) begin m_st = 0; m_px = 1; end
        3: if (ref_done) begin
             if (m_pr == 1) begin m_st = 2; m_pe = 1; end
             else if (m_pr == 2) begin
               if (qany) begin m_st = 2; m_pe = 1; end
               else begin m_st = 4; m_se = 1; end
             end else m_st = 0;
           end
        default: if (rdq_cnt != 0 || (wrq_cnt != 0 && bus_wr)) begin m_st = 0; m_sx = 1; end
      endcase
      if (m_px || m_sx) m_b = XIT_LAT;
      else if (m_b > 0) m_b = m_b - 1;
      m_cnt = nc;
    end
  end

  int prev_state = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(state == 3'(m_st), "R10 state", state, m_st);
      chk(pd_enter == m_pe, "R3 pd_enter", pd_enter, m_pe);
      chk(pd_exit == m_px, "R7 pd_exit", pd_exit, m_px);
      chk(sr_enter == m_se, "R6 sr_enter", sr_enter, m_se);
      chk(sr_exit == m_sx, "R8 sr_exit", sr_exit, m_sx);
      chk(busy == (m_b > 0), "R9 busy", busy, int'(m_b > 0));
      if (pd_enter && prev_state == 0)
        chk(m_cnt == 0 && lastq_empty, "R2 entry while not idle", m_cnt, 0);
    end
    prev_state = state;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr();
    evt_sched = 0; evt_done = 0; rd_ret = 0; pre_done = 0;
    ref_req = 0; ref_done = 0; acc_req = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      chk(0, "watchdog", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    chk(state == 0 && !pd_enter && !pd_exit && !sr_enter && !sr_exit && !busy,
        "R10 reset", state, 0);
    rst_n = 1; tick();

    // R1 R2: count 2 then 1; entry blocked
    evt_sched = 1; tick(); tick(); clr();
    evt_done = 1; tick(); clr();
    banks_closed = 0; rd_ret = 1; tick(); clr();
    chk(state == 0, "R2 blocked by count", state, 0);
    evt_sched = 1; evt_done = 1; rd_ret = 1; tick(); clr();
    chk(state == 0, "R1 simultaneous pulses hold count", state, 0);
    evt_done = 1; rd_ret = 1; tick(); clr();
    chk(state == 1 && pd_enter, "R3 active power-down entry", state, 1);
    tick();
    chk(!pd_enter && state == 1, "R3 strobe one cycle", pd_enter, 0);

    // R7 R9
    acc_req = 1; tick(); clr();
    chk(state == 0 && pd_exit && busy, "R7 access exit", state, 0);
    for (int i = 1; i < XIT_LAT; i++) begin
      tick(); chk(busy, "R9 busy held", busy, 1);
    end
    tick(); chk(!busy, "R9 busy released", busy, 0);

    // R1 floor at zero
    evt_done = 1; tick(); clr();
    evt_sched = 1; tick(); clr();
    banks_closed = 1; rd_ret = 1; tick(); clr();
    chk(state == 0, "R1 floor at zero", state, 0);
    evt_done = 1; pre_done = 1; tick(); clr();
    chk(state == 2 && pd_enter, "R4 precharge power-down entry", state, 2);

    // R5 R6
    ref_req = 1; tick(); clr();
    chk(state == 3 && pd_exit, "R5 exit for refresh", state, 3);
    ref_done = 1; tick(); clr();
    chk(state == 4 && sr_enter, "R6 self-refresh entry", state, 4);

    // R8
    wrq_cnt = 2; bus_wr = 0; tick(); tick();
    chk(state == 4 && !sr_exit, "R8 write queue on read bus stays", state, 4);
    bus_wr = 1; tick();
    chk(state == 0 && sr_exit, "R8 self-refresh exit", state, 0);
    wrq_cnt = 0; bus_wr = 0;
    repeat (XIT_LAT) tick();

    // R2 queues and access
    rdq_cnt = 1; pre_done = 1; tick(); clr();
    chk(state == 0, "R2 blocked by queue", state, 0);
    rdq_cnt = 0; acc_req = 1; pre_done = 1; tick(); clr();
    chk(state == 0, "R2 blocked by access", state, 0);

    // R7 priority, R5 from ACT_PDN
    banks_closed = 0; rd_ret = 1; tick(); clr();
    chk(state == 1, "R3 re-entry", state, 1);
    ref_req = 1; acc_req = 1; tick(); clr();
    chk(state == 3, "R7 refresh wins over access", state, 3);
    ref_done = 1; tick(); clr();
    chk(state == 2 && pd_enter, "R5 refresh after act pdn", state, 2);
    ref_req = 1; tick(); clr();
    chk(state == 3, "R5 refresh from pre pdn", state, 3);
    rdq_cnt = 1; ref_done = 1; tick(); clr();
    chk(state == 2 && pd_enter, "R6 queued returns to pre pdn", state, 2);
    acc_req = 1; tick(); clr(); rdq_cnt = 0;
    chk(state == 0 && pd_exit, "R7 exit from pre pdn", state, 0);
    repeat (XIT_LAT) tick();

    // R5 from ACTIVE
    ref_req = 1; tick(); clr();
    chk(state == 3 && !pd_exit, "R5 refresh from active", state, 3);
    ref_done = 1; tick(); clr();
    chk(state == 0 && !pd_enter, "R5 back to active", state, 0);

    repeat (4) tick();
    finish_run();
  end
endmodule